// File: doc/BRIEF.md
# Not-Recently-Used Replacement Victim Selector

This block holds the replacement state for a set-associative cache. It has one status bit for each way of each set. A set bit marks a way as a candidate for eviction. The cache controller tells the block about every hit and every line fill, giving the set index and the way. When a lookup misses, the controller presents the set index and reads back, in the same cycle, which way to evict. Tag comparison and data storage are outside the block.

A hit or a fill is an access, and an access clears the bit of the way it touches. If that clear would leave the set with no candidate at all, every other bit of the set is raised again and the accessed way stays clear. The victim is the lowest-numbered way whose bit is set, found by a priority encoder. A hit and a fill may arrive in the same cycle. When they name the same set, the fill is written first and the hit is held for one cycle, then applied before anything else that arrives in that later cycle.

Top module: `nru_victim_sel`

## Requirements
- R1: After reset every bit of every set is 1, so a miss to any set names way 0 as the victim.
- R2: A hit clears the status bit of the accessed way and leaves the other bits of that set and all other sets unchanged, unless R3 applies.
- R3: When an access would clear the only remaining 1 bit of a set, all other bits of that set become 1 and the accessed way's bit becomes 0. A set therefore never holds all zeros.
- R4: The victim is the lowest way index whose bit is 1, scanning upward from way 0.
- R5: A fill is an access to the filled way and follows the same update rule as a hit.
- R6: When a hit and a fill name the same set in one cycle, only the fill changes that set in that cycle. The hit is applied in the next cycle, before that cycle's fill and hit.
- R7: A hit and a fill that name different sets are both applied in the same cycle.
- R8: `victim_way` is combinational from `miss_set` and the current state, valid in the cycle of the miss request. A miss on its own changes no bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hit_valid | input | 1 | A hit access is presented |
| hit_set | input | clog2(SETS) | Set index of the hit |
| hit_way | input | clog2(WAYS) | Way index of the hit |
| fill_valid | input | 1 | A line fill is presented |
| fill_set | input | clog2(SETS) | Set index of the fill |
| fill_way | input | clog2(WAYS) | Way index of the fill |
| miss_valid | input | 1 | A miss request is presented |
| miss_set | input | clog2(SETS) | Set index of the miss |
| victim_way | output | clog2(WAYS) | Way to evict for `miss_set` |

## Verification
The bench builds the block with 4 sets and 4 ways. With so few ways, a run of accesses reaches the point where the last candidate bit is cleared and the set is refilled, and random traffic hits the same set often. That brings the same-set hit and fill collision, and the replay of the held hit, within reach many times. A reference model in the bench applies the update rules in their stated order. It predicts each victim and checks the state one cycle after a deferral and again after the replay.

// File: rtl/nru_pkg.sv
package nru_pkg;
  localparam int NRU_DEF_SETS = 64;
  localparam int NRU_DEF_WAYS = 16;

  // Index width for a count of items, at least one bit
  function automatic int idx_bits(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/nru_first_set.sv
module nru_first_set #(
  parameter int WAYS  = nru_pkg::NRU_DEF_WAYS,
  parameter int WAY_W = nru_pkg::idx_bits(WAYS)
) (
  input  logic [WAYS-1:0]  row,
  output logic [WAY_W-1:0] first_idx,
  output logic             any_set
);
  // Priority encoder: the lowest set bit wins
  always_comb begin
    first_idx = '0;
    any_set   = 1'b0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (row[w]) begin
        first_idx = WAY_W'(w);
        any_set   = 1'b1;
      end
    end
  end
endmodule

// File: rtl/nru_row_update.sv
module nru_row_update #(
  parameter int WAYS  = nru_pkg::NRU_DEF_WAYS,
  parameter int WAY_W = nru_pkg::idx_bits(WAYS)
) (
  input  logic [WAYS-1:0]  row_q,
  input  logic             pend_en,
  input  logic [WAY_W-1:0] pend_way,
  input  logic             fill_en,
  input  logic [WAY_W-1:0] fill_way,
  input  logic             hit_en,
  input  logic [WAY_W-1:0] hit_way,
  output logic [WAYS-1:0]  row_d
);
  // Clear the accessed bit; if nothing remains, raise all the others
  function automatic logic [WAYS-1:0] touch(input logic [WAYS-1:0] r,
                                            input logic [WAY_W-1:0] w);
    logic [WAYS-1:0] m;
    logic [WAYS-1:0] c;
    m    = '0;
    m[w] = 1'b1;
    c    = r & ~m;
    return (c == '0) ? ~m : c;
  endfunction

  logic [WAYS-1:0] after_pend;
  logic [WAYS-1:0] after_fill;

  // Order: held hit, then fill, then the new hit
  always_comb begin
    after_pend = pend_en ? touch(row_q, pend_way) : row_q;
    after_fill = fill_en ? touch(after_pend, fill_way) : after_pend;
    row_d      = hit_en ? touch(after_fill, hit_way) : after_fill;
  end
endmodule

// File: rtl/nru_defer.sv
module nru_defer #(
  parameter int SET_W = 6,
  parameter int WAY_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hit_valid,
  input  logic [SET_W-1:0] hit_set,
  input  logic [WAY_W-1:0] hit_way,
  input  logic             fill_valid,
  input  logic [SET_W-1:0] fill_set,
  output logic             defer_evt,
  output logic             pend_valid,
  output logic [SET_W-1:0] pend_set,
  output logic [WAY_W-1:0] pend_way
);
  assign defer_evt = hit_valid && fill_valid && (hit_set == fill_set);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_valid <= 1'b0;
      pend_set   <= '0;
      pend_way   <= '0;
    end else begin
      pend_valid <= defer_evt;
      if (defer_evt) begin
        pend_set <= hit_set;
        pend_way <= hit_way;
      end
    end
  end

  // R6: a held hit is released after exactly one cycle
  p_pend_one_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pend_valid && !defer_evt |=> !pend_valid);
  p_defer_captures_r6: assert property (@(posedge clk) disable iff (!rst_n)
    defer_evt |=> pend_valid && pend_way == $past(hit_way));
endmodule

// File: rtl/nru_victim_sel.sv
module nru_victim_sel #(
  parameter int SETS  = nru_pkg::NRU_DEF_SETS,
  parameter int WAYS  = nru_pkg::NRU_DEF_WAYS,
  localparam int SET_W = nru_pkg::idx_bits(SETS),
  localparam int WAY_W = nru_pkg::idx_bits(WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hit_valid,
  input  logic [SET_W-1:0] hit_set,
  input  logic [WAY_W-1:0] hit_way,
  input  logic             fill_valid,
  input  logic [SET_W-1:0] fill_set,
  input  logic [WAY_W-1:0] fill_way,
  input  logic             miss_valid,
  input  logic [SET_W-1:0] miss_set,
  output logic [WAY_W-1:0] victim_way
);
  logic [WAYS-1:0] rows_q [SETS];
  logic [WAYS-1:0] rows_d [SETS];

  logic             defer_evt;
  logic             pend_valid;
  logic [SET_W-1:0] pend_set;
  logic [WAY_W-1:0] pend_way;
  logic             hit_now;
  logic             miss_only;
  logic             victim_any;
  logic [WAYS-1:0]  miss_row;

  nru_defer #(.SET_W(SET_W), .WAY_W(WAY_W)) u_defer (
    .clk        (clk),
    .rst_n      (rst_n),
    .hit_valid  (hit_valid),
    .hit_set    (hit_set),
    .hit_way    (hit_way),
    .fill_valid (fill_valid),
    .fill_set   (fill_set),
    .defer_evt  (defer_evt),
    .pend_valid (pend_valid),
    .pend_set   (pend_set),
    .pend_way   (pend_way)
  );

  // Named events for the checks
  assign hit_now   = hit_valid && !defer_evt;
  assign miss_only = miss_valid && !hit_valid && !fill_valid && !pend_valid;

  for (genvar s = 0; s < SETS; s++) begin : g_set
    logic pend_en;
    logic fill_en;
    logic hit_en;
    assign pend_en = pend_valid && (pend_set == SET_W'(s));
    assign fill_en = fill_valid && (fill_set == SET_W'(s));
    assign hit_en  = hit_now && (hit_set == SET_W'(s));

    nru_row_update #(.WAYS(WAYS), .WAY_W(WAY_W)) u_upd (
      .row_q    (rows_q[s]),
      .pend_en  (pend_en),
      .pend_way (pend_way),
      .fill_en  (fill_en),
      .fill_way (fill_way),
      .hit_en   (hit_en),
      .hit_way  (hit_way),
      .row_d    (rows_d[s])
    );

    always_ff @(posedge clk) begin
      if (!rst_n) rows_q[s] <= '1;
      else        rows_q[s] <= rows_d[s];
    end

    // R3: no set is ever left without a candidate
    p_row_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      rows_q[s] != '0);
  end

  assign miss_row = rows_q[miss_set];

  nru_first_set #(.WAYS(WAYS), .WAY_W(WAY_W)) u_find (
    .row       (miss_row),
    .first_idx (victim_way),
    .any_set   (victim_any)
  );

  // R4: the chosen way is a candidate and no lower way is
  p_victim_is_candidate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    miss_valid |-> victim_any && miss_row[victim_way]);
  p_victim_lowest_r4: assert property (@(posedge clk) disable iff (!rst_n)
    miss_valid |-> (miss_row & ((WAYS'(1) << victim_way) - WAYS'(1))) == '0);
  // R2: an applied hit leaves its way clear
  p_hit_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    hit_now && !(pend_valid && pend_set == hit_set)
      |=> rows_q[$past(hit_set)][$past(hit_way)] == 1'b0);
  // R5: a fill always leaves its way clear (a same-set hit waits)
  p_fill_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid |=> rows_q[$past(fill_set)][$past(fill_way)] == 1'b0);
  // R8: a lone miss writes nothing
  p_miss_no_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    miss_only |=> rows_q[$past(miss_set)] == $past(miss_row));
endmodule

// File: tb/tb_nru_victim_sel.sv
module tb_nru_victim_sel;
  localparam int SETS = 4;
  localparam int WAYS = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hit_valid = 1'b0, fill_valid = 1'b0, miss_valid = 1'b0;
  logic [1:0] hit_set = '0, hit_way = '0, fill_set = '0, fill_way = '0;
  logic [1:0] miss_set = '0;
  logic [1:0] victim_way;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  nru_victim_sel #(.SETS(SETS), .WAYS(WAYS)) dut (
    .clk(clk), .rst_n(rst_n),
    .hit_valid(hit_valid), .hit_set(hit_set), .hit_way(hit_way),
    .fill_valid(fill_valid), .fill_set(fill_set), .fill_way(fill_way),
    .miss_valid(miss_valid), .miss_set(miss_set), .victim_way(victim_way)
  );

  typedef struct { int exp; string req; } item_t;
  item_t sb [$];

  // Reference model
  bit [WAYS-1:0] m_rows [SETS];
  bit m_pv; int m_ps, m_pw;

  function automatic bit [WAYS-1:0] m_touch(bit [WAYS-1:0] r, int w);
    bit [WAYS-1:0] n = r;
    n[w] = 1'b0;
    if (n == 0) begin
      n = '1;
      n[w] = 1'b0;
    end
    return n;
  endfunction

  function automatic int m_victim(bit [WAYS-1:0] r);
    for (int w = 0; w < WAYS; w++) if (r[w]) return w;
    return -1;
  endfunction

  task automatic cyc(bit hv, int hs, int hw, bit fv, int fs, int fw,
                     bit mv, int ms, string req);
    bit nd;
    @(negedge clk);
    hit_valid = hv; hit_set = 2'(hs); hit_way = 2'(hw);
    fill_valid = fv; fill_set = 2'(fs); fill_way = 2'(fw);
    miss_valid = mv; miss_set = 2'(ms);
    if (mv) sb.push_back('{m_victim(m_rows[ms]), req});
    if (m_pv) m_rows[m_ps] = m_touch(m_rows[m_ps], m_pw);
    if (fv) m_rows[fs] = m_touch(m_rows[fs], fw);
    nd = hv && fv && (hs == fs);
    if (hv && !nd) m_rows[hs] = m_touch(m_rows[hs], hw);
    m_pv = nd; m_ps = hs; m_pw = hw;
  endtask

  task automatic idle();
    cyc(0, 0, 0, 0, 0, 0, 0, 0, "");
  endtask

  // Monitor: compare victim with the oldest expected item
  always @(negedge clk) begin
    #2;
    if (rst_n && miss_valid) begin
      item_t it;
      it = sb.pop_front();
      n_checks++;
      if (int'(victim_way) != it.exp) begin
        n_errors++;
        $display("FAIL %s: victim_way=%0d expected=%0d", it.req, victim_way, it.exp);
      end
    end
  end

  initial begin
    #(200000 * 8);
    n_errors++;
    $display("FAIL watchdog: run did not end, actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    for (int s = 0; s < SETS; s++) m_rows[s] = '1;
    m_pv = 0; m_ps = 0; m_pw = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: every set starts with all candidates
    for (int s = 0; s < SETS; s++) cyc(0, 0, 0, 0, 0, 0, 1, s, "R1");
    // R8: repeated lone misses keep the same victim
    cyc(0, 0, 0, 0, 0, 0, 1, 1, "R8");
    cyc(0, 0, 0, 0, 0, 0, 1, 1, "R8");
    // R2: hit way 0 of set 0, victim moves to way 1; other sets untouched
    cyc(1, 0, 0, 0, 0, 0, 0, 0, "");
    cyc(0, 0, 0, 0, 0, 0, 1, 0, "R2");
    cyc(0, 0, 0, 0, 0, 0, 1, 3, "R2");
    // R4: clear ways 1 and 3 in set 1 after way 0, leaving way 2
    cyc(1, 1, 0, 0, 0, 0, 0, 0, "");
    cyc(1, 1, 1, 0, 0, 0, 1, 1, "R4");
    cyc(1, 1, 3, 0, 0, 0, 1, 1, "R4");
    cyc(0, 0, 0, 0, 0, 0, 1, 1, "R4");
    // R3: clearing the last bit (way 2) refills ways 0,1,3
    cyc(1, 1, 2, 0, 0, 0, 0, 0, "");
    cyc(0, 0, 0, 0, 0, 0, 1, 1, "R3");
    cyc(1, 1, 0, 0, 0, 0, 0, 0, "");
    cyc(0, 0, 0, 0, 0, 0, 1, 1, "R3");
    // R5: fills of ways 0 and 1 in set 3
    cyc(0, 0, 0, 1, 3, 0, 0, 0, "");
    cyc(0, 0, 0, 1, 3, 1, 1, 3, "R5");
    cyc(0, 0, 0, 0, 0, 0, 1, 3, "R5");
    // R6: set 2 to 0011, then fill way 0 and hit way 1 together
    cyc(1, 2, 2, 0, 0, 0, 0, 0, "");
    cyc(1, 2, 3, 0, 0, 0, 0, 0, "");
    cyc(1, 2, 1, 1, 2, 0, 1, 2, "R6");
    cyc(0, 0, 0, 0, 0, 0, 1, 2, "R6");
    cyc(0, 0, 0, 0, 0, 0, 1, 2, "R6");
    // R7: hit and fill to different sets in one cycle
    cyc(1, 0, 1, 1, 3, 2, 0, 0, "");
    cyc(0, 0, 0, 0, 0, 0, 1, 0, "R7");
    cyc(0, 0, 0, 0, 0, 0, 1, 3, "R7");
    // Mixed random traffic on all rules
    for (int i = 0; i < 400; i++) begin
      cyc(($urandom % 3) != 0, $urandom % SETS, $urandom % WAYS,
          ($urandom % 2) != 0, $urandom % SETS, $urandom % WAYS,
          1, $urandom % SETS, "R3/R6 random");
    end
    idle();
    idle();
    if (sb.size() != 0) begin
      n_errors++;
      $display("FAIL R8: pending items=%0d expected=0", sb.size());
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule